// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Register Interface

This block holds the digital register logic for a two-channel, 8-bit converter with a parallel host bus. The host selects a channel, pulls chip select and the write strobe low, and puts a byte on the data bus. When the write strobe rises, that byte goes into the selected channel's input register. Each channel also has a DAC register, whose 8-bit code is the block's output toward the converter. The converter voltage is 2 × Vref × N / 256, where N is the straight-binary code from 0 to 255.

At the rising edge of the write strobe, the level of the active-low load strobe decides when the DAC register takes the new value. If the load strobe is low, the selected channel's DAC register is loaded at once. If it is high, nothing moves until the next falling edge of the load strobe, which loads both DAC registers together. All host pins pass through two-flop synchronizers. Strobe edges are found in the clock domain, and every register changes on a single clock edge.

After reset the block sits in a power-on state: all codes are zero and a flag is raised until the first accepted write. An active-low power-down pin freezes every register and drops an output-enable indication.

Top module: `dual_dac_regif`

## Requirements
- R1: A write is accepted when chip select is low at the synchronized rising edge of the write strobe. The data byte goes into input register A when the channel-select bit is 0, and into input register B when it is 1.
- R2: If the load strobe is low at an accepted write, the selected channel's output code takes the written byte and the other channel's code is unchanged.
- R3: If the load strobe is high at an accepted write, both output codes stay unchanged. The next falling edge of the load strobe copies both input registers into both output codes at once.
- R4: Only a falling edge of the load strobe transfers data. A later deferred write leaves the codes unchanged while the load strobe stays high, even if the strobe was low earlier.
- R5: A write strobe rising edge with chip select high changes no register and does not end the power-on state.
- R6: After reset both codes are 0 and `por_active` is 1. `por_active` falls on the first accepted write, in either update mode, and stays low until the next reset. A load-strobe fall does not clear it.
- R7: While `pd_n` is low, `out_en` is 0 and write and load-strobe edges are ignored, so both codes keep their values. When `pd_n` returns high, `out_en` is 1 again and the codes are the same as before power-down.
- R8: If an accepted write with the load strobe low and a load-strobe falling edge fall in the same clock cycle, the write is applied first. Both codes then equal both input registers, including the new byte.
- R9: A pin change that causes an update appears on the output codes after the third rising clock edge that follows it, and not after the second.
- R10: Asserting `rst_n` at any time returns the block to the power-on state of R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_sel | input | 1 | Channel select: 0 = A, 1 = B |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; data taken on its rising edge |
| ld_n | input | 1 | Active-low load strobe |
| pd_n | input | 1 | Active-low power-down |
| din | input | 8 | Host data byte |
| code_a | output | 8 | Code driving converter A |
| code_b | output | 8 | Code driving converter B |
| por_active | output | 1 | High while the power-on state lasts |
| out_en | output | 1 | Low while powered down |

## Verification
An automatic write update and a load-strobe falling edge can fall in the same clock cycle. In that cycle, one DAC register is asked to load twice, from two sources. The bench provokes this by raising the write strobe and lowering the load strobe in a single pin update, so both edges reach the synchronized domain together. The result is judged against the rule that the write lands first: after the collision, both codes must equal both input registers, with the new byte in the selected channel and the older value in the other.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;
  localparam int unsigned NUM_CH      = 2;
  localparam int unsigned SYNC_STAGES = 2;
  typedef enum logic {CH_A = 1'b0, CH_B = 1'b1} ch_sel_e;
endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = pin_i;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dac_strobe_ctl.sv
module dac_strobe_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic wr_s,
  input  logic ld_s,
  input  logic pd_s,
  output logic wr_evt,
  output logic ld_evt,
  output logic auto_upd,
  output logic por_active
);
  logic wr_prev_q, ld_prev_q, por_q;
  logic por_d;
  logic wr_rise, ld_fall;

  assign wr_rise  = wr_s & ~wr_prev_q;
  assign ld_fall  = ~ld_s & ld_prev_q;
  assign wr_evt   = wr_rise & ~cs_s & pd_s;
  assign ld_evt   = ld_fall & pd_s;
  assign auto_upd = ~ld_s;

  always_comb begin
    por_d = por_q;
    if (wr_evt) por_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q <= 1'b1;
      ld_prev_q <= 1'b1;
      por_q     <= 1'b1;
    end else begin
      wr_prev_q <= wr_s;
      ld_prev_q <= ld_s;
      por_q     <= por_d;
    end
  end

  assign por_active = por_q;
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              xfer_en,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] in_code_o,
  output logic [DATA_W-1:0] dac_code_o
);
  logic [DATA_W-1:0] in_q, in_d, dac_q, dac_d;

  always_comb begin
    in_d  = wr_en   ? data_i : in_q;
    dac_d = xfer_en ? in_d   : dac_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      if (wr_en)   in_q  <= in_d;
      if (xfer_en) dac_q <= dac_d;
    end
  end

  assign in_code_o  = in_q;
  assign dac_code_o = dac_q;
endmodule

// File: rtl/dual_dac_regif.sv
module dual_dac_regif
  import dac_regif_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_sel,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic              pd_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic              por_active,
  output logic              out_en
);
  localparam int unsigned DBUS_W = DATA_W + 1;

  logic              rst_meta_q, rst_sync_n;
  logic [3:0]        ctl_s;
  logic [DBUS_W-1:0] dbus_s;
  logic              wr_evt, ld_evt, auto_upd;
  logic [DATA_W-1:0] in_code  [NUM_CH];
  logic [DATA_W-1:0] dac_code [NUM_CH];
  logic [DATA_W-1:0] in_code_a, in_code_b;
  ch_sel_e           sel_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  dac_pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_ctl_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .pin_i({pd_n, ld_n, wr_n, cs_n}), .sync_o(ctl_s)
  );

  dac_pin_sync #(.W(DBUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .pin_i({chan_sel, din}), .sync_o(dbus_s)
  );

  assign sel_s = ch_sel_e'(dbus_s[DATA_W]);

  dac_strobe_ctl u_ctl (
    .clk(clk), .rst_n(rst_sync_n),
    .cs_s(ctl_s[0]), .wr_s(ctl_s[1]), .ld_s(ctl_s[2]), .pd_s(ctl_s[3]),
    .wr_evt(wr_evt), .ld_evt(ld_evt), .auto_upd(auto_upd),
    .por_active(por_active)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic sel_hit, wr_en, xfer_en;
    assign sel_hit = (sel_s == ch_sel_e'(ch));
    assign wr_en   = wr_evt & sel_hit;
    assign xfer_en = (wr_en & auto_upd) | ld_evt;
    dac_channel #(.DATA_W(DATA_W)) u_chan (
      .clk(clk), .rst_n(rst_sync_n),
      .wr_en(wr_en), .xfer_en(xfer_en), .data_i(dbus_s[DATA_W-1:0]),
      .in_code_o(in_code[ch]), .dac_code_o(dac_code[ch])
    );
  end

  assign in_code_a = in_code[0];
  assign in_code_b = in_code[1];
  assign code_a    = dac_code[0];
  assign code_b    = dac_code[1];
  assign out_en    = ctl_s[3];
endmodule

// File: rtl/dual_dac_regif_chk.sv
module dual_dac_regif_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] code_a,
  input logic [DATA_W-1:0] code_b,
  input logic [DATA_W-1:0] in_code_a,
  input logic [DATA_W-1:0] in_code_b,
  input logic              por_active,
  input logic              out_en,
  input logic              wr_evt,
  input logic              ld_evt,
  input logic              auto_upd
);
  // R6: power-on state shows zero codes
  assert_por_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    por_active |-> (code_a == '0 && code_b == '0));

  // R6: power-on flag never comes back without reset
  assert_por_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !por_active |=> !por_active);

  // R7: frozen codes while powered down
  assert_pd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> ($stable(code_a) && $stable(code_b)));

  // R3: deferred write leaves codes alone
  assert_defer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !auto_upd && !ld_evt) |=> ($stable(code_a) && $stable(code_b)));

  // R3 / R8: load edge leaves both codes equal to both input registers
  assert_ld_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_evt |=> (code_a == in_code_a && code_b == in_code_b));

  // R4: no edge, no change
  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_evt && !ld_evt) |=> ($stable(code_a) && $stable(code_b)));
endmodule

bind dual_dac_regif dual_dac_regif_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .code_a(code_a), .code_b(code_b),
  .in_code_a(in_code_a), .in_code_b(in_code_b),
  .por_active(por_active), .out_en(out_en),
  .wr_evt(wr_evt), .ld_evt(ld_evt), .auto_upd(auto_upd)
);

// File: tb/dual_dac_regif_test.sv
`timescale 1ns/1ps
module dual_dac_regif_test;
  logic       clk = 1'b0;
  logic       rst_n, chan_sel, cs_n, wr_n, ld_n, pd_n;
  logic [7:0] din, code_a, code_b;
  logic       por_active, out_en;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  dual_dac_regif uut (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .cs_n(cs_n), .wr_n(wr_n),
    .ld_n(ld_n), .pd_n(pd_n), .din(din), .code_a(code_a), .code_b(code_b),
    .por_active(por_active), .out_en(out_en)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; chan_sel = 1'b0; cs_n = 1'b1; wr_n = 1'b1;
    ld_n = 1'b1; pd_n = 1'b1; din = 8'h00;
    wait_cyc(3);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(6);
  endtask

  // full write cycle; ld_lvl is the load-strobe level held around the rising edge
  task automatic host_write(input logic ch, input logic [7:0] d, input logic ld_lvl,
                            input logic cs_lvl);
    @(negedge clk);
    chan_sel = ch; din = d; ld_n = ld_lvl; cs_n = cs_lvl; wr_n = 1'b0;
    wait_cyc(4);
    @(negedge clk); wr_n = 1'b1;
    wait_cyc(4);
    @(negedge clk); cs_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic ld_pulse();
    @(negedge clk); ld_n = 1'b0; wait_cyc(5);
    @(negedge clk); ld_n = 1'b1; wait_cyc(5);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R6 reset code_a", code_a, 0);
    chk("R6 reset code_b", code_b, 0);
    chk("R6 reset por_active", por_active, 1);
    chk("R7 reset out_en", out_en, 1);
    ld_pulse();
    chk("R6 ld fall keeps por", por_active, 1);
  endtask

  task automatic t_cs_ignored();
    do_reset();
    host_write(1'b0, 8'h5A, 1'b0, 1'b1);
    chk("R5 cs high code_a", code_a, 0);
    chk("R5 cs high por", por_active, 1);
    ld_pulse();
    chk("R5 cs high input A untouched", code_a, 0);
  endtask

  task automatic t_auto();
    do_reset();
    host_write(1'b0, 8'hA5, 1'b0, 1'b0);
    chk("R2 auto code_a", code_a, 8'hA5);
    chk("R2 auto code_b untouched", code_b, 0);
    chk("R6 por cleared by write", por_active, 0);
    host_write(1'b1, 8'hFF, 1'b0, 1'b0);
    chk("R1 channel B write", code_b, 8'hFF);
    chk("R2 code_a kept", code_a, 8'hA5);
  endtask

  task automatic t_latency();
    do_reset();
    @(negedge clk);
    chan_sel = 1'b1; din = 8'h3C; ld_n = 1'b0; cs_n = 1'b0; wr_n = 1'b0;
    wait_cyc(4);
    @(negedge clk); wr_n = 1'b1;
    wait_cyc(2);
    chk("R9 not yet after two edges", code_b, 0);
    wait_cyc(1);
    chk("R9 updated after third edge", code_b, 8'h3C);
    @(negedge clk); cs_n = 1'b1; wait_cyc(4);
  endtask

  task automatic t_deferred();
    do_reset();
    host_write(1'b0, 8'h11, 1'b1, 1'b0);
    chk("R6 deferred write clears por", por_active, 0);
    host_write(1'b1, 8'h22, 1'b1, 1'b0);
    chk("R3 deferred code_a held", code_a, 0);
    chk("R3 deferred code_b held", code_b, 0);
    ld_pulse();
    chk("R3 ld fall code_a", code_a, 8'h11);
    chk("R3 ld fall code_b", code_b, 8'h22);
    host_write(1'b0, 8'h99, 1'b1, 1'b0);
    wait_cyc(20);
    chk("R4 no transfer without new fall", code_a, 8'h11);
    ld_pulse();
    chk("R4 new fall transfers", code_a, 8'h99);
  endtask

  task automatic t_collision();
    do_reset();
    host_write(1'b1, 8'h44, 1'b1, 1'b0);
    @(negedge clk);
    chan_sel = 1'b0; din = 8'h77; cs_n = 1'b0; ld_n = 1'b1; wr_n = 1'b0;
    wait_cyc(4);
    @(negedge clk); wr_n = 1'b1; ld_n = 1'b0;
    wait_cyc(4);
    chk("R8 collision code_a new byte", code_a, 8'h77);
    chk("R8 collision code_b pending byte", code_b, 8'h44);
    @(negedge clk); cs_n = 1'b1; ld_n = 1'b1; wait_cyc(4);
  endtask

  task automatic t_power_down();
    do_reset();
    host_write(1'b0, 8'h12, 1'b0, 1'b0);
    host_write(1'b1, 8'h34, 1'b1, 1'b0);
    @(negedge clk); pd_n = 1'b0; wait_cyc(4);
    chk("R7 out_en low", out_en, 0);
    host_write(1'b0, 8'hEE, 1'b0, 1'b0);
    ld_pulse();
    chk("R7 pd code_a kept", code_a, 8'h12);
    chk("R7 pd code_b kept", code_b, 0);
    @(negedge clk); pd_n = 1'b1; wait_cyc(4);
    chk("R7 out_en back", out_en, 1);
    ld_pulse();
    chk("R7 pending B survives pd", code_b, 8'h34);
    chk("R7 pd write dropped", code_a, 8'h12);
  endtask

  task automatic t_mid_reset();
    host_write(1'b0, 8'h80, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b0; wait_cyc(1);
    chk("R10 reset code_a", code_a, 0);
    chk("R10 reset por", por_active, 1);
    @(negedge clk); rst_n = 1'b1; wait_cyc(6);
    chk("R10 after release code_b", code_b, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_cs_ignored();
    t_auto();
    t_latency();
    t_deferred();
    t_collision();
    t_power_down();
    t_mid_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule